// File: doc/BRIEF.md
# Virtual Interrupt Signaling Controller

This block decides, cycle by cycle, which asynchronous exception a processor core takes when hypervisor-driven virtual interrupts and physical interrupt lines compete. Three exception kinds are handled: IRQ, FIQ and SError. A virtual request is raised either by a hypervisor control bit or by the virtual CPU interface of an interrupt controller, and both are treated alike. A virtual request only counts while the routing bit of its kind is set. The same routing bit steers the physical line of that kind to the hypervisor level (EL2). With the routing bit clear, the physical line goes to the guest kernel level (EL1).

Requests are captured on their rising edge into pending state. A captured request stays pending while its source stays high and it is blocked by a mask or by the current exception level. It is dropped if its source falls before it is taken. Each cycle a fixed-priority picker grants at most one eligible request. The grant is reported as a registered one-cycle pulse that carries the exception kind, the target level and a virtual/physical flag. The granted request then leaves the pending state.

Top module: `virq_signal_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, `take_o` is low and nothing is pending, so no pulse appears until a source rises after reset.
- R2: Bit positions in `route_i`, `vctl_i`, `phys_i` and `mask_i` are 0 = IRQ, 1 = FIQ, 2 = SError. `take_kind_o` uses the same codes. A control bit with its routing bit set, at EL0 or EL1, yields a pulse with `take_el_o` = 1 and `take_virt_o` = 1.
- R3: `vif_irq_i` and `vif_fiq_i` behave exactly like control bits 0 and 1.
- R4: A virtual source whose routing bit is clear produces no pulse.
- R5: A virtual request is never taken while `cur_el_i` is 2 or 3. It stays pending and is taken once the level drops to 0 or 1.
- R6: A masked request targeting EL1 is not taken but stays pending. It is taken on the cycle after the mask clears.
- R7: At most one pulse per cycle. Among requests of the same tier, SError wins over FIQ, and FIQ wins over IRQ. Losers are taken on the following cycles.
- R8: A physical line whose routing bit is set is taken to EL2 (`take_virt_o` = 0) from EL0 or EL1 regardless of its mask, and ahead of every virtual request.
- R9: A physical line whose routing bit is clear targets EL1 with `take_virt_o` = 0. It obeys its mask and is only taken at EL0 or EL1.
- R10: While at EL2, a routed physical line is taken to EL2 only when unmasked. At EL3, nothing is taken.
- R11: Each rising edge of a source gives at most one pulse: a source held high is not taken again. A request whose source falls before it is taken is discarded.
- R12: A source that rises before clock edge k is captured at edge k. If it is eligible, its pulse is high for the single cycle after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_el_i | input | EL_W | Current exception level |
| route_i | input | 3 | Per-kind routing bits to the hypervisor level |
| vctl_i | input | 3 | Per-kind hypervisor virtual-interrupt control bits |
| vif_irq_i | input | 1 | Virtual IRQ line from the virtual CPU interface |
| vif_fiq_i | input | 1 | Virtual FIQ line from the virtual CPU interface |
| phys_i | input | 3 | Per-kind physical interrupt lines |
| mask_i | input | 3 | Per-kind exception masks |
| take_o | output | 1 | One-cycle exception-taken pulse |
| take_kind_o | output | 2 | Kind of the taken exception |
| take_el_o | output | EL_W | Target exception level |
| take_virt_o | output | 1 | Taken exception is virtual |

## Verification
The bench builds the block with its defaults, EL_W = 2, HYP_EL = 2 and GUEST_EL = 1. This width reaches all four exception levels, so the blocking of every request at EL3 and the separate EL2 behaviour can both be driven. A behavioural reference model of pending state and priority is compared on every clock. Directed sequences then cover routing, masking, level changes, simultaneous requests and withdrawn requests.

// File: rtl/vsig_pkg.sv
package vsig_pkg;
  localparam int NKIND = 3;
  localparam int NCAND = 2 * NKIND;
  typedef enum logic [1:0] {
    K_IRQ  = 2'd0,
    K_FIQ  = 2'd1,
    K_SERR = 2'd2
  } kind_e;
endpackage

// File: rtl/vsig_pend.sv
module vsig_pend #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;

  assign rise = lvl_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= lvl_i & (pend_q | rise) & ~clr_i;
    end
  end

  assign pend_o = pend_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R11
    cleared_gone_chk: assert property (@(posedge clk) disable iff (rst)
      clr_i[k] |=> !pend_q[k]);
    // R11
    drop_follows_source_chk: assert property (@(posedge clk) disable iff (rst)
      !lvl_i[k] |=> !pend_q[k]);
  end
endmodule

// File: rtl/vsig_elig.sv
module vsig_elig
  import vsig_pkg::*;
#(
  parameter int EL_W   = 2,
  parameter int HYP_EL = 2
) (
  input  logic [EL_W-1:0]  cur_el_i,
  input  logic [NKIND-1:0] route_i,
  input  logic [NKIND-1:0] mask_i,
  input  logic [NKIND-1:0] pphys_i,
  input  logic [NKIND-1:0] pvirt_i,
  output logic [NCAND-1:0] cand_o
);
  logic guest;
  logic at_hyp;

  assign guest  = cur_el_i < EL_W'(HYP_EL);
  assign at_hyp = cur_el_i == EL_W'(HYP_EL);

  // Index 0..NKIND-1: routed physical, highest kind first.
  // Index NKIND..NCAND-1: EL1-targeted, highest kind first.
  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign cand_o[NKIND-1-k] = pphys_i[k] & route_i[k] &
                               (guest | (at_hyp & ~mask_i[k]));
    assign cand_o[NCAND-1-k] = guest & ~mask_i[k] &
                               ((pvirt_i[k] & route_i[k]) | (pphys_i[k] & ~route_i[k]));
  end
endmodule

// File: rtl/vsig_pick.sv
module vsig_pick #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] grant_o
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar c = 0; c < N; c++) begin : g_pri
    assign grant_o[c]   = cand_i[c] & ~blocked[c];
    assign blocked[c+1] = blocked[c] | cand_i[c];
  end

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  // R7
  grant_needs_cand_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_i != '0) |-> (grant_o != '0));
endmodule

// File: rtl/virq_signal_ctrl.sv
module virq_signal_ctrl
  import vsig_pkg::*;
#(
  parameter int EL_W     = 2,
  parameter int HYP_EL   = 2,
  parameter int GUEST_EL = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EL_W-1:0] cur_el_i,
  input  logic [2:0]      route_i,
  input  logic [2:0]      vctl_i,
  input  logic            vif_irq_i,
  input  logic            vif_fiq_i,
  input  logic [2:0]      phys_i,
  input  logic [2:0]      mask_i,
  output logic            take_o,
  output logic [1:0]      take_kind_o,
  output logic [EL_W-1:0] take_el_o,
  output logic            take_virt_o
);
  logic [NKIND-1:0] vif_vec;
  logic [NKIND-1:0] vlvl;
  logic [NKIND-1:0] pphys, pvirt;
  logic [NKIND-1:0] pclr, vclr;
  logic [NCAND-1:0] cand, grant;

  logic             nx_take;
  kind_e            nx_kind;
  logic [EL_W-1:0]  nx_el;
  logic             nx_virt;

  assign vif_vec = {1'b0, vif_fiq_i, vif_irq_i};
  assign vlvl    = route_i & (vctl_i | vif_vec);

  vsig_pend #(.N(NKIND)) i_phys_pend (
    .clk(clk), .rst(rst), .lvl_i(phys_i), .clr_i(pclr), .pend_o(pphys)
  );

  vsig_pend #(.N(NKIND)) i_virt_pend (
    .clk(clk), .rst(rst), .lvl_i(vlvl), .clr_i(vclr), .pend_o(pvirt)
  );

  vsig_elig #(.EL_W(EL_W), .HYP_EL(HYP_EL)) i_elig (
    .cur_el_i(cur_el_i), .route_i(route_i), .mask_i(mask_i),
    .pphys_i(pphys), .pvirt_i(pvirt), .cand_o(cand)
  );

  vsig_pick #(.N(NCAND)) i_pick (
    .clk(clk), .rst(rst), .cand_i(cand), .grant_o(grant)
  );

  for (genvar k = 0; k < NKIND; k++) begin : g_clr
    assign pclr[k] = grant[NKIND-1-k] | (grant[NCAND-1-k] & ~route_i[k]);
    assign vclr[k] = grant[NCAND-1-k] & route_i[k];
  end

  always_comb begin
    nx_take = 1'b0;
    nx_kind = K_IRQ;
    nx_el   = '0;
    nx_virt = 1'b0;
    for (int c = 0; c < NCAND; c++) begin
      if (grant[c]) begin
        nx_take = 1'b1;
        if (c < NKIND) begin
          nx_kind = kind_e'(NKIND - 1 - c);
          nx_el   = EL_W'(HYP_EL);
          nx_virt = 1'b0;
        end else begin
          nx_kind = kind_e'(NCAND - 1 - c);
          nx_el   = EL_W'(GUEST_EL);
          nx_virt = route_i[NCAND-1-c];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o      <= 1'b0;
      take_kind_o <= '0;
      take_el_o   <= '0;
      take_virt_o <= 1'b0;
    end else begin
      take_o      <= nx_take;
      take_kind_o <= nx_kind;
      take_el_o   <= nx_el;
      take_virt_o <= nx_virt;
    end
  end

  // R5
  virt_below_hyp_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && take_virt_o) |-> ($past(cur_el_i) < EL_W'(HYP_EL)));
  // R8
  hyp_target_routed_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && take_el_o == EL_W'(HYP_EL)) |->
      ((($past(route_i) >> take_kind_o) & 3'b001) == 3'b001));
  // R6
  guest_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && take_el_o == EL_W'(GUEST_EL)) |->
      ((($past(mask_i) >> take_kind_o) & 3'b001) == 3'b000));
  // R10
  nothing_at_top_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cur_el_i) == '1) |-> !take_o);
endmodule

// File: tb/test_virq_signal_ctrl.sv
module test_virq_signal_ctrl;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cur_el = 2'd1;
  logic [2:0] route = '0, vctl = '0, phys = '0, mask = '0;
  logic       vif_irq = 1'b0, vif_fiq = 1'b0;
  logic       take;
  logic [1:0] take_kind, take_el;
  logic       take_virt;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(PERIOD/2) clk = ~clk;

  virq_signal_ctrl i_virq_signal_ctrl (
    .clk(clk), .rst(rst), .cur_el_i(cur_el), .route_i(route), .vctl_i(vctl),
    .vif_irq_i(vif_irq), .vif_fiq_i(vif_fiq), .phys_i(phys), .mask_i(mask),
    .take_o(take), .take_kind_o(take_kind), .take_el_o(take_el),
    .take_virt_o(take_virt)
  );

  // Behavioural reference model
  int  m_pp[3], m_vp[3], m_pprev[3], m_vprev[3];
  bit  e_take, e_virt;
  int  e_kind, e_el;

  always @(posedge clk) begin
    int  lv[3];
    bit  pc[3], vc[3];
    bit  hit;
    bit  guest;
    lv[0] = route[0] && (vctl[0] || vif_irq);
    lv[1] = route[1] && (vctl[1] || vif_fiq);
    lv[2] = route[2] && vctl[2];
    if (rst) begin
      for (int k = 0; k < 3; k++) begin
        m_pp[k] = 0; m_vp[k] = 0; m_pprev[k] = 0; m_vprev[k] = 0;
      end
      e_take = 0; e_kind = 0; e_el = 0; e_virt = 0;
    end else begin
      guest = cur_el < 2;
      hit = 0; e_take = 0; e_kind = 0; e_el = 0; e_virt = 0;
      for (int k = 0; k < 3; k++) begin pc[k] = 0; vc[k] = 0; end
      for (int k = 2; k >= 0; k--)
        if (!hit && m_pp[k] != 0 && route[k] &&
            (guest || (cur_el == 2 && !mask[k]))) begin
          hit = 1; e_take = 1; e_kind = k; e_el = 2; pc[k] = 1;
        end
      for (int k = 2; k >= 0; k--)
        if (!hit && guest && !mask[k]) begin
          if (m_vp[k] != 0 && route[k]) begin
            hit = 1; e_take = 1; e_kind = k; e_el = 1; e_virt = 1; vc[k] = 1;
          end else if (m_pp[k] != 0 && !route[k]) begin
            hit = 1; e_take = 1; e_kind = k; e_el = 1; pc[k] = 1;
          end
        end
      for (int k = 0; k < 3; k++) begin
        m_pp[k] = (phys[k] && (m_pp[k] != 0 || m_pprev[k] == 0) && !pc[k]) ? 1 : 0;
        m_vp[k] = (lv[k] != 0 && (m_vp[k] != 0 || m_vprev[k] == 0) && !vc[k]) ? 1 : 0;
        m_pprev[k] = phys[k];
        m_vprev[k] = lv[k];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (take !== e_take || (e_take &&
          (take_kind !== e_kind[1:0] || take_el !== e_el[1:0] || take_virt !== e_virt))) begin
        bad++;
        $display("FAIL R12 model: got take=%0b kind=%0d el=%0d virt=%0b exp take=%0b kind=%0d el=%0d virt=%0b",
                 take, take_kind, take_el, take_virt, e_take, e_kind, e_el, e_virt);
      end
    end
  end

  task automatic chk(string req, bit v, int k, int el, bit vi);
    total++;
    if (take !== v || (v && (take_kind !== k[1:0] || take_el !== el[1:0] || take_virt !== vi))) begin
      bad++;
      $display("FAIL %s: got take=%0b kind=%0d el=%0d virt=%0b exp take=%0b kind=%0d el=%0d virt=%0b",
               req, take, take_kind, take_el, take_virt, v, k, el, vi);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    route = '0; vctl = '0; phys = '0; mask = '0;
    vif_irq = 0; vif_fiq = 0; cur_el = 2'd1;
    tick(3);
  endtask

  initial begin
    tick(3);
    chk("R1 in reset", 0, 0, 0, 0);
    rst = 0;
    tick(2);
    chk("R1 after reset", 0, 0, 0, 0);

    // R2, R12, R11
    route[0] = 1; vctl[0] = 1;
    tick(1); chk("R12 no early pulse", 0, 0, 0, 0);
    tick(1); chk("R2 virtual IRQ", 1, 0, 1, 1);
    tick(1); chk("R11 held level no retake", 0, 0, 0, 0);
    quiet();

    // R3
    cur_el = 0; route[1] = 1; vif_fiq = 1;
    tick(2); chk("R3 interface FIQ", 1, 1, 1, 1);
    quiet();
    route[0] = 1; vif_irq = 1;
    tick(2); chk("R3 interface IRQ", 1, 0, 1, 1);
    quiet();

    // R4
    vctl[1] = 1; vif_irq = 1;
    tick(2); chk("R4 unrouted virtual", 0, 0, 0, 0);
    tick(1); chk("R4 unrouted virtual later", 0, 0, 0, 0);
    quiet();

    // R5
    cur_el = 2; route[1] = 1; vctl[1] = 1;
    tick(3); chk("R5 blocked at EL2", 0, 0, 0, 0);
    cur_el = 3;
    tick(2); chk("R5 blocked at EL3", 0, 0, 0, 0);
    cur_el = 1;
    tick(1); chk("R5 taken after drop", 1, 1, 1, 1);
    quiet();

    // R6
    route[2] = 1; mask[2] = 1; vctl[2] = 1;
    tick(3); chk("R6 masked held", 0, 0, 0, 0);
    mask[2] = 0;
    tick(1); chk("R6 taken after unmask", 1, 2, 1, 1);
    quiet();

    // R7
    route = 3'b111; vctl = 3'b111;
    tick(2); chk("R7 SError first", 1, 2, 1, 1);
    tick(1); chk("R7 FIQ second", 1, 1, 1, 1);
    tick(1); chk("R7 IRQ third", 1, 0, 1, 1);
    tick(1); chk("R7 then idle", 0, 0, 0, 0);
    quiet();

    // R8
    cur_el = 0; mask = 3'b111; route[0] = 1; vctl[0] = 1; phys[0] = 1;
    tick(2); chk("R8 routed physical to EL2 despite mask", 1, 0, 2, 0);
    tick(1); chk("R8 virtual still masked", 0, 0, 0, 0);
    mask = '0;
    tick(1); chk("R8 virtual after unmask", 1, 0, 1, 1);
    quiet();
    route[0] = 1; vctl[0] = 1; route[2] = 1; phys[2] = 1; vctl[2] = 1;
    tick(2); chk("R8 physical ahead of virtual", 1, 2, 2, 0);
    tick(1); chk("R8 virtual SError next", 1, 2, 1, 1);
    tick(1); chk("R8 virtual IRQ last", 1, 0, 1, 1);
    quiet();

    // R9
    phys[1] = 1;
    tick(2); chk("R9 unrouted physical to EL1", 1, 1, 1, 0);
    quiet();
    cur_el = 2; phys[0] = 1;
    tick(3); chk("R9 unrouted physical blocked at EL2", 0, 0, 0, 0);
    cur_el = 1;
    tick(1); chk("R9 taken at EL1", 1, 0, 1, 0);
    quiet();

    // R10
    cur_el = 2; route[2] = 1; phys[2] = 1; mask[2] = 1;
    tick(3); chk("R10 masked at EL2", 0, 0, 0, 0);
    mask[2] = 0;
    tick(1); chk("R10 unmasked at EL2", 1, 2, 2, 0);
    quiet();
    cur_el = 3; route[1] = 1; phys[1] = 1;
    tick(3); chk("R10 nothing at EL3", 0, 0, 0, 0);
    quiet();

    // R11 withdrawn
    route[0] = 1; mask[0] = 1; vctl[0] = 1;
    tick(2);
    vctl[0] = 0;
    tick(1);
    mask[0] = 0;
    tick(1); chk("R11 withdrawn request dropped", 0, 0, 0, 0);
    tick(1); chk("R11 withdrawn stays dropped", 0, 0, 0, 0);
    quiet();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R12 watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule